// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Controller

This block is the slave-side command front end of a serial NOR flash. It runs on a system clock, oversamples the serial clock, chip select and serial data input through a synchroniser, and samples data on rising serial-clock edges while chip select is low. Three instructions are handled. Write-enable arms a latch. Read-status shifts a status byte out on the serial output. Sector-erase takes an 8-bit opcode and a 24-bit address, most significant bit first.

A sector erase starts only when several conditions hold. Chip select must rise exactly on the byte boundary after the last address bit. The enable latch must already be set. The target sector must lie outside the region selected by the block-protect setting. When all of these hold, the block sends a one-cycle erase request with the sector index to an external array stub and clears the enable latch. It then holds the write-in-progress flag for a fixed number of clock cycles to model the self-timed erase. The array is a 16-sector, 64 KB-per-sector space. Address bits 19:16 select the sector and the upper address bits are ignored.

Top module: `sfc_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 8'h00 (with block-protect input 0), `erase_req` is 0 and `spi_miso` is 0.
- R2: Opcode 8'h06 sets the enable latch (status bit 1) only if chip select rises after exactly 8 bits. A frame of 7 or 9 bits leaves the latch unchanged.
- R3: Opcode 8'h05 returns the status byte {3'b000, bp[2:0], enable (bit 1), busy (bit 0)}. It is driven MSB first on falling serial-clock edges, starting on the falling edge after the eighth opcode bit, and repeats while chip select stays low. `spi_miso` is 0 outside this window.
- R4: Opcode 8'hD8 followed by 24 address bits, with chip select rising after exactly 32 bits and the enable latch set, raises `erase_req` for exactly one clock. `erase_sector` equals address bits 19:16 in that clock, and in the same clock the busy bit reads 1 and the enable latch reads 0.
- R5: The busy bit stays 1 for exactly ERASE_CYCLES clock cycles, starting with the cycle of the request, then returns to 0.
- R6: A sector-erase frame sent while the enable latch is 0 produces no request and leaves the busy bit 0.
- R7: A sector-erase frame whose chip select rises after any bit count other than 32 (for example 31 or 33) produces no request and leaves the enable latch set.
- R8: A block-protect value n (1 to 7) protects the top 2^(n-1) sectors, and every sector when n is 5 or more. Value 0 protects nothing. An erase aimed at a protected sector produces no request, leaves the busy bit 0 and keeps the enable latch set.
- R9: While the busy bit is 1, write-enable and sector-erase frames are ignored, and read-status still works.
- R10: Any other opcode is ignored, whatever its frame length, and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data input |
| spi_miso | output | 1 | Serial data output (status byte only) |
| bp_cfg | input | BP_W | Block-protect setting, shown in status bits 4:2 |
| erase_req | output | 1 | One-cycle erase strobe to the array stub |
| erase_sector | output | SECT_W | Sector index qualified by `erase_req` |

## Verification
The bound checker watches every clock. It confirms that the erase strobe is one cycle wide and appears only when the enable latch was set and the controller was idle. It checks that the strobe never names a protected sector, that the busy flag lasts exactly the configured number of cycles, and that the enable latch rises only on a chip-select rising edge outside a busy period. Frame-level behaviour can only be shown by the bench's scenarios: the 7/9-bit and 31/33-bit boundary cases, the bit order and repetition of the status byte, the upper address bits being ignored, unknown opcodes, and instructions that arrive during an erase.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_SERA = 8'hD8;
   localparam int         OP_W    = 8;
   localparam int         STAT_W  = 8;

   typedef struct packed {
      logic sck;
      logic csn;
      logic mosi;
   } pins_t;

   localparam pins_t PINS_IDLE = '{sck: 1'b0, csn: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/sfc_pin_sync.sv
module sfc_pin_sync
   import sfc_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_in,
   input  logic csn_in,
   input  logic mosi_in,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_fall,
   output logic cs_rise,
   output logic cs_act,
   output logic mosi_s
);
   pins_t raw, synced, prev;

   assign raw = '{sck: sck_in, csn: csn_in, mosi: mosi_in};

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         pins_t chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= PINS_IDLE;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign synced = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= PINS_IDLE;
      else        prev <= synced;
   end

   assign sck_rise = synced.sck & ~prev.sck;
   assign sck_fall = ~synced.sck & prev.sck;
   assign cs_fall  = ~synced.csn & prev.csn;
   assign cs_rise  = synced.csn & ~prev.csn;
   assign cs_act   = ~synced.csn;
   assign mosi_s   = synced.mosi;
endmodule

// File: rtl/sfc_cmd_rx.sv
module sfc_cmd_rx
   import sfc_pkg::*;
#(
   parameter int FRAME_W = 32,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_fall,
   input  logic               cs_act,
   input  logic               sck_rise,
   input  logic               mosi_s,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic [OP_W-1:0]    opcode,
   output logic [FRAME_W-1:0] frame
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_W - 1);

   logic [FRAME_W-1:0] next_frame;
   assign next_frame = {frame[FRAME_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         opcode  <= '0;
         frame   <= '0;
      end else if (cs_fall) begin
         bit_cnt <= '0;
         opcode  <= '0;
         frame   <= '0;
      end else if (cs_act && sck_rise) begin
         frame <= next_frame;
         if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == OP_LAST) opcode <= next_frame[OP_W-1:0];
      end
   end
endmodule

// File: rtl/sfc_status_tx.sv
module sfc_status_tx
   import sfc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_fall,
   input  logic              rd_en,
   input  logic [STAT_W-1:0] stat,
   output logic              miso
);
   localparam int IW = $clog2(STAT_W);

   logic [IW-1:0]     idx;
   logic [STAT_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miso <= 1'b0;
         idx  <= '0;
         sr   <= '0;
      end else if (!cs_act) begin
         miso <= 1'b0;
         idx  <= '0;
      end else if (rd_en && sck_fall) begin
         if (idx == '0) begin
            miso <= stat[STAT_W-1];
            sr   <= {stat[STAT_W-2:0], 1'b0};
         end else begin
            miso <= sr[STAT_W-1];
            sr   <= {sr[STAT_W-2:0], 1'b0};
         end
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/sfc_erase_timer.sv
module sfc_erase_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else if (start) begin
         busy <= 1'b1;
         left <= CW'(CYCLES - 1);
      end else if (busy) begin
         if (left == '0) busy <= 1'b0;
         else            left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/sfc_protect.sv
module sfc_protect #(
   parameter int SECT_W = 4,
   parameter int BP_W   = 3
) (
   input  logic [BP_W-1:0]   bp,
   input  logic [SECT_W-1:0] sector,
   output logic              prot
);
   logic [SECT_W-1:0] low_mask;
   int                k;

   always_comb begin
      prot     = 1'b0;
      low_mask = '0;
      k        = int'(bp) - 1;
      if (bp != '0) begin
         if (k >= SECT_W) begin
            prot = 1'b1;
         end else begin
            low_mask = (SECT_W'(1) << k) - SECT_W'(1);
            prot     = &(sector | low_mask);
         end
      end
   end
endmodule

// File: rtl/sfc_erase_ctrl.sv
module sfc_erase_ctrl
   import sfc_pkg::*;
#(
   parameter int ERASE_CYCLES = 1000,
   parameter int SYNC_STAGES  = 2,
   parameter int ADDR_W       = 24,
   parameter int SECT_LSB     = 16,
   parameter int SECT_W       = 4,
   parameter int BP_W         = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_csn,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic [BP_W-1:0]   bp_cfg,
   output logic              erase_req,
   output logic [SECT_W-1:0] erase_sector
);
   localparam int FRAME_W = OP_W + ADDR_W;
   localparam int CNT_W   = $clog2(FRAME_W) + 2;
   localparam logic [CNT_W-1:0] LEN_OP    = CNT_W'(OP_W);
   localparam logic [CNT_W-1:0] LEN_FRAME = CNT_W'(FRAME_W);

   if (ERASE_CYCLES < 1) begin : g_bad_cycles
      $error("ERASE_CYCLES must be at least 1");
   end
   if (SECT_LSB + SECT_W > ADDR_W) begin : g_bad_sect
      $error("sector field must lie inside the address");
   end
   if (BP_W + 2 > STAT_W) begin : g_bad_bp
      $error("block-protect field does not fit the status byte");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic               sck_rise, sck_fall, cs_fall, cs_rise, cs_act, mosi_s;
   logic [CNT_W-1:0]   bit_cnt;
   logic [OP_W-1:0]    opcode;
   logic [FRAME_W-1:0] frame;
   logic [SECT_W-1:0]  sect_sel;
   logic               prot;
   logic               wel, wip;
   logic               start, wren_hit, rd_en;
   logic [STAT_W-1:0]  stat;

   sfc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sck_in(spi_sck), .csn_in(spi_csn), .mosi_in(spi_mosi),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s)
   );

   sfc_cmd_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .cs_fall(cs_fall), .cs_act(cs_act), .sck_rise(sck_rise), .mosi_s(mosi_s),
      .bit_cnt(bit_cnt), .opcode(opcode), .frame(frame)
   );

   assign sect_sel = frame[SECT_LSB +: SECT_W];

   sfc_protect #(.SECT_W(SECT_W), .BP_W(BP_W)) u_prot (
      .bp(bp_cfg), .sector(sect_sel), .prot(prot)
   );

   assign start    = cs_rise && (opcode == OP_SERA) && (bit_cnt == LEN_FRAME)
                     && wel && !wip && !prot;
   assign wren_hit = cs_rise && (opcode == OP_WREN) && (bit_cnt == LEN_OP) && !wip;
   assign rd_en    = (opcode == OP_RDSR) && (bit_cnt >= LEN_OP);

   sfc_erase_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(wip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel          <= 1'b0;
         erase_req    <= 1'b0;
         erase_sector <= '0;
      end else begin
         erase_req <= start;
         if (start) begin
            wel          <= 1'b0;
            erase_sector <= sect_sel;
         end else if (wren_hit) begin
            wel <= 1'b1;
         end
      end
   end

   assign stat = STAT_W'({bp_cfg, wel, wip});

   sfc_status_tx u_tx (
      .clk(clk), .rst_n(rst_n),
      .cs_act(cs_act), .sck_fall(sck_fall), .rd_en(rd_en),
      .stat(stat), .miso(spi_miso)
   );
endmodule

// File: rtl/sfc_erase_ctrl_chk.sv
module sfc_erase_ctrl_chk #(
   parameter int ERASE_CYCLES = 1000,
   parameter int SECT_W       = 4,
   parameter int BP_W         = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              erase_req,
   input logic [SECT_W-1:0] erase_sector,
   input logic [BP_W-1:0]   bp_cfg,
   input logic              wel,
   input logic              wip,
   input logic              cs_rise
);
   localparam int NSECT = 1 << SECT_W;

   int  busy_cnt;
   logic sect_prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   busy_cnt <= 0;
      else if (wip) busy_cnt <= busy_cnt + 1;
      else          busy_cnt <= 0;
   end

   always_comb begin
      int span;
      span = 0;
      if (bp_cfg != '0) begin
         if (int'(bp_cfg) - 1 >= SECT_W) span = NSECT;
         else                            span = 1 << (int'(bp_cfg) - 1);
      end
      sect_prot = (span != 0) && (int'(erase_sector) >= NSECT - span);
   end

   // R4
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);

   // R4
   req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (wip && !wel));

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wip && $past(wip)) |-> (busy_cnt == ERASE_CYCLES));

   // R6
   req_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(wel));

   // R9
   req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> !$past(wip));

   // R8
   req_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> !sect_prot);

   // R2
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> ($past(cs_rise) && !$past(wip)));
endmodule

bind sfc_erase_ctrl sfc_erase_ctrl_chk #(
   .ERASE_CYCLES(ERASE_CYCLES), .SECT_W(SECT_W), .BP_W(BP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .erase_sector(erase_sector),
   .bp_cfg(bp_cfg), .wel(wel), .wip(wip), .cs_rise(cs_rise)
);

// File: tb/sim_sfc_erase_ctrl.sv
module sim_sfc_erase_ctrl;
   localparam int ECYC = 2000;
   localparam int HP   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic       miso;
   logic [2:0] bp = 3'd0;
   logic       erase_req;
   logic [3:0] erase_sector;

   int total = 0, bad = 0;
   int cyc = 0, pulses = 0, run = 0, wide = 0, req_cyc = 0;
   logic [3:0] last_sec = '0;
   logic       done = 1'b0;

   always #4 clk = ~clk;

   sfc_erase_ctrl #(.ERASE_CYCLES(ECYC)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
      .spi_miso(miso), .bp_cfg(bp), .erase_req(erase_req), .erase_sector(erase_sector)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (erase_req) begin
         pulses   <= pulses + 1;
         last_sec <= erase_sector;
         req_cyc  <= cyc;
         run      <= run + 1;
         if (run >= 1) wide <= 1;
      end else begin
         run <= 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic frame_io(input logic [63:0] dout, input int nbits, output logic [63:0] din);
      din = '0;
      @(negedge clk) csn = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         mosi = dout[i];
         repeat (HP) @(negedge clk);
         din[i] = miso;
         sck = 1'b1;
         repeat (HP) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HP) @(negedge clk);
      csn = 1'b1;
      repeat (4 * HP) @(negedge clk);
   endtask

   task automatic send(input logic [63:0] dout, input int nbits);
      logic [63:0] d;
      frame_io(dout, nbits, d);
   endtask

   task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
      logic [63:0] d;
      frame_io({40'd0, 8'h05, 16'h0000}, 24, d);
      s0 = d[15:8];
      s1 = d[7:0];
   endtask

   task automatic expect_status(input logic [7:0] exp, input string tag);
      logic [7:0] s0, s1;
      read_status(s0, s1);
      chk(s0 == exp, tag, s0, exp);
   endtask

   task automatic wren();
      send(64'h06, 8);
   endtask

   task automatic erase(input logic [23:0] addr);
      send({32'd0, 8'hD8, addr}, 32);
   endtask

   task automatic t_reset();
      chk(erase_req == 1'b0, "R1 erase_req", erase_req, 0);
      chk(miso == 1'b0, "R1 miso", miso, 0);
      expect_status(8'h00, "R1 status");
   endtask

   task automatic t_wren_len();
      send(64'h06 >> 1, 7);
      expect_status(8'h00, "R2 7-bit wren");
      send({63'h06, 1'b0}, 9);
      expect_status(8'h00, "R2 9-bit wren");
      wren();
      expect_status(8'h02, "R2 wren sets latch");
   endtask

   task automatic t_rdsr();
      logic [7:0] s0, s1;
      bp = 3'd2;
      read_status(s0, s1);
      chk(s0 == 8'h0A, "R3 first byte", s0, 8'h0A);
      chk(s1 == 8'h0A, "R3 repeated byte", s1, 8'h0A);
      chk(miso == 1'b0, "R3 idle miso", miso, 0);
      bp = 3'd0;
   endtask

   task automatic t_unknown();
      int p;
      p = pulses;
      send({32'd0, 8'h20, 24'h010000}, 32);
      send(64'h04, 8);
      chk(pulses == p, "R10 no pulse", pulses, p);
      expect_status(8'h02, "R10 status kept");
   endtask

   task automatic t_boundary();
      int p;
      p = pulses;
      send({32'd0, 8'hD8, 24'h010000} >> 1, 31);
      send({31'd0, 8'hD8, 24'h010000, 1'b0}, 33);
      chk(pulses == p, "R7 no pulse", pulses, p);
      expect_status(8'h02, "R7 latch kept");
   endtask

   task automatic t_erase_ok();
      int p;
      logic [7:0] s0, s1;
      p = pulses;
      erase(24'hF3ABCD);
      chk(pulses == p + 1, "R4 one pulse", pulses, p + 1);
      chk(wide == 0, "R4 pulse width", wide, 0);
      chk(last_sec == 4'd3, "R4 sector", last_sec, 3);
      expect_status(8'h01, "R4 busy set latch clear");
      // R9: write-enable and erase during busy are ignored, read-status works
      wren();
      erase(24'h050000);
      chk(pulses == p + 1, "R9 no second pulse", pulses, p + 1);
      while (cyc < req_cyc + ECYC - 600) @(negedge clk);
      expect_status(8'h01, "R5 still busy");
      while (cyc < req_cyc + ECYC + 10) @(negedge clk);
      read_status(s0, s1);
      chk(s0 == 8'h00, "R5 busy done", s0, 8'h00);
      chk(s1 == 8'h00, "R9 wren ignored while busy", s1, 8'h00);
   endtask

   task automatic t_no_wel();
      int p;
      p = pulses;
      erase(24'h020000);
      chk(pulses == p, "R6 no pulse", pulses, p);
      expect_status(8'h00, "R6 not busy");
   endtask

   task automatic t_protect();
      int p;
      bp = 3'd3;
      wren();
      p = pulses;
      erase(24'h0C1234);
      chk(pulses == p, "R8 protected ignored", pulses, p);
      expect_status(8'h0E, "R8 latch kept not busy");
      erase(24'h0BFFFF);
      chk(pulses == p + 1, "R8 edge sector accepted", pulses, p + 1);
      chk(last_sec == 4'd11, "R8 sector", last_sec, 11);
      repeat (ECYC + 20) @(negedge clk);
      bp = 3'd5;
      wren();
      p = pulses;
      erase(24'h000000);
      chk(pulses == p, "R8 all protected", pulses, p);
      bp = 3'd1;
      erase(24'h0F0000);
      chk(pulses == p, "R8 top sector protected", pulses, p);
      erase(24'h0E0000);
      chk(pulses == p + 1, "R8 sector 14 open", pulses, p + 1);
      chk(last_sec == 4'd14, "R8 sector 14", last_sec, 14);
      repeat (ECYC + 20) @(negedge clk);
      bp = 3'd0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_wren_len();
      t_rdsr();
      t_unknown();
      t_boundary();
      t_erase_ok();
      t_no_wel();
      t_protect();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule